// File: doc/BRIEF.md
# Multi-Queue Shared-RAM FIFO Manager

This block runs 64 independent circular FIFOs inside a single word-wide buffer RAM of 1984 words (0x1F00 bytes). Each queue has its own configuration word. The word sets the queue's base word address in the RAM, its depth (16, 32, 64 or 128 words), its entry width (1, 2 or 4 words), and two watermark levels counted in entries. The block keeps a read pointer, a write pointer and a word count for every queue. From these it drives per-queue empty, nearly-empty, nearly-full and full flags to a separate status block. It also pulses underflow and overflow events for the lower 32 queues.

A host moves data with single-word accesses on a simple request/response bus.

- **Push:** to push an entry of N words, the host writes words 0..N-1 of the queue's 16-byte access window.
- **Pop:** to pop an entry, the host reads the same words.
- **Pointer update:** the pointers and the count change only on the last word of the entry.
- **Indexed access:** a separate indexed region gives read and write access to any word of a queue, counted from its head, without moving either pointer.

Reads answer one cycle after the request.

Top module: `mq_fifo_mgr`

## Requirements
- R1: After reset every queue is empty with no events pending. Its flags read empty=1, nearly-empty=1, nearly-full=0 and full=0. Its configuration is base 0, 16 words deep, 1-word entries and both watermarks 0.
- R2: Byte address 16*q+4*k (q 0..63, k 0..3) is word k of the access window of queue q. Any request whose address bits [1:0] are not zero is ignored.
- R3: A push writes window words 0..N-1, where N is the entry width. A pop reads the same words. Entries come out in FIFO order, and the pointers and count change only on the access to word N-1.
- R4: Entry-width code 0, 1 and 2 selects 1, 2 and 4 words. Code 3 is illegal, and a window access to such a queue stores nothing, reads zero, moves no pointer and raises no event.
- R5: A pop from an empty queue reads zero on every word and leaves the pointers unchanged. For queues 0..31, the last word of that pop pulses that queue's bit of q_uflow for one cycle.
- R6: A push to a full queue drops its data and leaves the pointers unchanged. For queues 0..31, the last word of that push pulses that queue's bit of q_oflow for one cycle. Queues 32..63 never raise an event.
- R7: empty is set when the count is zero, and full is set when the count equals the depth.
- R8: nearly-empty is set when the stored entries are at or below the NE watermark. nearly-full is set when the free entries are at or below the NF watermark.
- R9: The configuration word of queue q is at byte 0x400+4*q, with these fields:
  - [10:0]: base word address
  - [13:12]: depth code, depth = 16 << code words
  - [17:16]: entry-width code
  - [22:20]: NE watermark
  - [26:24]: NF watermark

  Writing the word empties the queue. Reading it returns the fields, with all other bits zero.
- R10: Byte address 0x8000 + 512*q + 4*j reads or writes the word j places past the head of queue q, wrapping within the queue's depth. Neither pointer moves.
- R11: Pointers wrap at the queue depth, and queues with disjoint RAM ranges do not disturb one another.
- R12: Every read request gives rsp_valid=1 and its data in the next cycle. A write gives no response.
- R13: A RAM word address at or above 1984 stores nothing and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read request) |
| rsp_rdata | output | 32 | Read data |
| q_empty | output | 64 | Per-queue empty flag |
| q_nempty | output | 64 | Per-queue nearly-empty flag |
| q_nfull | output | 64 | Per-queue nearly-full flag |
| q_full | output | 64 | Per-queue full flag |
| q_uflow | output | 32 | Underflow pulse, queues 0..31 |
| q_oflow | output | 32 | Overflow pulse, queues 0..31 |

## Verification
The assertions assume at most one request per cycle. They also assume the host does not rewrite a queue's configuration halfway through an entry, and that queues given disjoint RAM ranges are not aliased through a base address.

The stimulus configures a fresh queue before using it and completes each entry in word order. It keeps the randomly driven queues on separate 128-word ranges. Misaligned, illegal-width and out-of-range accesses are used only in directed cases whose effect is checked at the ports.

// File: rtl/mqf_pkg.sv
package mqf_pkg;
  localparam int BASE_W   = 11;
  localparam int DCODE_W  = 2;
  localparam int ESZ_W    = 2;
  localparam int WM_W     = 3;
  localparam int MIN_DEPTH = 16;
  localparam int MAX_DEPTH = MIN_DEPTH << ((1 << DCODE_W) - 1);
  localparam int PTR_W    = $clog2(MAX_DEPTH);
  localparam int CNT_W    = PTR_W + 1;

  // configuration word field positions
  localparam int CF_BASE = 0;
  localparam int CF_DC   = 12;
  localparam int CF_ESZ  = 16;
  localparam int CF_NE   = 20;
  localparam int CF_NF   = 24;

  typedef enum logic [1:0] {ACC_NONE, ACC_WIN, ACC_CFG, ACC_IDX} acc_kind_e;
  typedef enum logic [1:0] {SRC_ZERO, SRC_RAM, SRC_CFG} rsp_src_e;

  typedef struct packed {
    logic [WM_W-1:0]    nf_wm;
    logic [WM_W-1:0]    ne_wm;
    logic [ESZ_W-1:0]   esz;
    logic [DCODE_W-1:0] dcode;
    logic [BASE_W-1:0]  base;
  } qcfg_t;

  function automatic qcfg_t cfg_unpack(input logic [31:0] w);
    qcfg_t c;
    c.base  = w[CF_BASE +: BASE_W];
    c.dcode = w[CF_DC   +: DCODE_W];
    c.esz   = w[CF_ESZ  +: ESZ_W];
    c.ne_wm = w[CF_NE   +: WM_W];
    c.nf_wm = w[CF_NF   +: WM_W];
    return c;
  endfunction

  function automatic logic [31:0] cfg_pack(input qcfg_t c);
    logic [31:0] w;
    w = '0;
    w[CF_BASE +: BASE_W]  = c.base;
    w[CF_DC   +: DCODE_W] = c.dcode;
    w[CF_ESZ  +: ESZ_W]   = c.esz;
    w[CF_NE   +: WM_W]    = c.ne_wm;
    w[CF_NF   +: WM_W]    = c.nf_wm;
    return w;
  endfunction

  function automatic logic [CNT_W-1:0] depth_words(input logic [DCODE_W-1:0] dc);
    return CNT_W'(MIN_DEPTH) << dc;
  endfunction
endpackage

// File: rtl/mqf_decode.sv
module mqf_decode
  import mqf_pkg::*;
#(
  parameter int QID_W = 6,
  parameter int OFF_W = 7,
  localparam int ADDR_W = QID_W + OFF_W + 3,
  localparam int TAG_LO = QID_W + 4
) (
  input  logic [ADDR_W-1:0] addr,
  output acc_kind_e         kind,
  output logic [QID_W-1:0]  qid,
  output logic [1:0]        wsel,
  output logic [OFF_W-1:0]  off
);
  logic [ADDR_W-2-TAG_LO:0] tag;
  assign tag = addr[ADDR_W-2:TAG_LO];

  always_comb begin
    kind = ACC_NONE;
    qid  = addr[2 +: QID_W];
    wsel = addr[3:2];
    off  = addr[2 +: OFF_W];
    if (addr[1:0] != 2'd0) begin
      kind = ACC_NONE;
    end else if (addr[ADDR_W-1]) begin
      kind = ACC_IDX;
      qid  = addr[OFF_W+2 +: QID_W];
    end else if (tag == '0) begin
      kind = ACC_WIN;
      qid  = addr[4 +: QID_W];
    end else if (tag == 1 && addr[QID_W+3:QID_W+2] == 2'd0) begin
      kind = ACC_CFG;
    end
  end
endmodule

// File: rtl/mqf_buffer_ram.sv
module mqf_buffer_ram #(
  parameter int WORDS = 1984,
  parameter int AW    = 11
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);
  logic [31:0] mem [WORDS];
  logic        hit;

  assign hit = 32'(addr) < 32'(WORDS);

  always_ff @(posedge clk) begin
    if (en && we && hit) mem[addr] <= wdata;
    if (en && !we)       rdata <= hit ? mem[addr] : 32'd0;
  end
endmodule

// File: rtl/mqf_queue_ctl.sv
module mqf_queue_ctl
  import mqf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  qcfg_t            cfg_in,
  input  logic             push_last,
  input  logic             pop_last,
  output qcfg_t            cfg_q,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [PTR_W-1:0] wr_ptr,
  output logic             empty,
  output logic             nempty,
  output logic             nfull,
  output logic             full
);
  logic [CNT_W-1:0] count, cnt_n, depth, nwords, entries, free_ent;
  logic [PTR_W-1:0] rd_n, wr_n, mask;
  qcfg_t            cfg_n;
  logic             upd;

  assign depth    = depth_words(cfg_q.dcode);
  assign mask     = PTR_W'(depth - CNT_W'(1));
  assign nwords   = CNT_W'(1) << cfg_q.esz;
  assign entries  = count >> cfg_q.esz;
  assign free_ent = (depth - count) >> cfg_q.esz;
  assign empty    = (count == '0);
  assign full     = (count == depth);
  assign nempty   = entries <= CNT_W'(cfg_q.ne_wm);
  assign nfull    = free_ent <= CNT_W'(cfg_q.nf_wm);
  assign upd      = cfg_we | push_last | pop_last;

  always_comb begin
    cfg_n = cfg_q;
    rd_n  = rd_ptr;
    wr_n  = wr_ptr;
    cnt_n = count;
    if (cfg_we) begin
      cfg_n = cfg_in;
      rd_n  = '0;
      wr_n  = '0;
      cnt_n = '0;
    end else if (push_last && !full) begin
      wr_n  = (wr_ptr + nwords[PTR_W-1:0]) & mask;
      cnt_n = count + nwords;
    end else if (pop_last && !empty) begin
      rd_n  = (rd_ptr + nwords[PTR_W-1:0]) & mask;
      cnt_n = count - nwords;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else if (upd) begin
      cfg_q  <= cfg_n;
      rd_ptr <= rd_n;
      wr_ptr <= wr_n;
      count  <= cnt_n;
    end
  end

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= depth);
  a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (push_last && full && !cfg_we) |=> $stable(wr_ptr) && $stable(count));
  a_r5_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_last && empty && !cfg_we) |=> $stable(rd_ptr) && $stable(count));
  a_r3_push_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (push_last && !full && !cfg_we) |=> count == $past(count) + $past(nwords));
endmodule

// File: rtl/mq_fifo_mgr.sv
module mq_fifo_mgr
  import mqf_pkg::*;
#(
  parameter int NUM_Q     = 64,
  parameter int EVT_Q     = 32,
  parameter int RAM_WORDS = 1984,
  localparam int QID_W    = $clog2(NUM_Q),
  localparam int ADDR_W   = QID_W + PTR_W + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NUM_Q-1:0]  q_empty,
  output logic [NUM_Q-1:0]  q_nempty,
  output logic [NUM_Q-1:0]  q_nfull,
  output logic [NUM_Q-1:0]  q_full,
  output logic [EVT_Q-1:0]  q_uflow,
  output logic [EVT_Q-1:0]  q_oflow
);
  acc_kind_e        kind;
  logic [QID_W-1:0] qid;
  logic [1:0]       wsel;
  logic [PTR_W-1:0] ioff;

  mqf_decode #(.QID_W(QID_W), .OFF_W(PTR_W)) u_dec (
    .addr(req_addr), .kind(kind), .qid(qid), .wsel(wsel), .off(ioff));

  qcfg_t            cfg_a [NUM_Q];
  logic [PTR_W-1:0] rd_a  [NUM_Q];
  logic [PTR_W-1:0] wr_a  [NUM_Q];
  qcfg_t            cur;
  logic             sel_full, sel_empty, legal, in_entry, is_last, win;
  logic             push_word, pop_word, push_last, pop_last, idx_acc, cfg_we;
  logic [2:0]       nwords;
  logic [PTR_W-1:0] off_sel, ptr_sel, lin, mask;
  logic [BASE_W-1:0] ram_addr;
  logic             ram_en, ram_we;
  logic [31:0]      ram_q;

  assign cur       = cfg_a[qid];
  assign sel_full  = q_full[qid];
  assign sel_empty = q_empty[qid];
  assign nwords    = 3'd1 << cur.esz;
  assign legal     = cur.esz != 2'd3;
  assign in_entry  = {1'b0, wsel} < nwords;
  assign is_last   = {1'b0, wsel} == (nwords - 3'd1);
  assign win       = req_valid && kind == ACC_WIN && legal;
  assign push_word = win && req_write && in_entry && !sel_full;
  assign pop_word  = win && !req_write && in_entry && !sel_empty;
  assign push_last = win && req_write && is_last;
  assign pop_last  = win && !req_write && is_last;
  assign idx_acc   = req_valid && kind == ACC_IDX;
  assign cfg_we    = req_valid && req_write && kind == ACC_CFG;

  // address into the shared RAM: base plus masked position inside the ring
  assign mask     = PTR_W'(depth_words(cur.dcode) - CNT_W'(1));
  assign off_sel  = idx_acc ? ioff : PTR_W'(wsel);
  assign ptr_sel  = (idx_acc || !req_write) ? rd_a[qid] : wr_a[qid];
  assign lin      = (ptr_sel + off_sel) & mask;
  assign ram_addr = cur.base + BASE_W'(lin);
  assign ram_en   = push_word || pop_word || idx_acc;
  assign ram_we   = push_word || (idx_acc && req_write);

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    mqf_queue_ctl u_ctl (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we && qid == QID_W'(g)),
      .cfg_in   (cfg_unpack(req_wdata)),
      .push_last(push_last && qid == QID_W'(g)),
      .pop_last (pop_last && qid == QID_W'(g)),
      .cfg_q    (cfg_a[g]),
      .rd_ptr   (rd_a[g]),
      .wr_ptr   (wr_a[g]),
      .empty    (q_empty[g]),
      .nempty   (q_nempty[g]),
      .nfull    (q_nfull[g]),
      .full     (q_full[g])
    );
  end

  mqf_buffer_ram #(.WORDS(RAM_WORDS), .AW(BASE_W)) u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(req_wdata), .rdata(ram_q));

  // event and response next-state
  logic [EVT_Q-1:0] uflow_n, oflow_n;
  rsp_src_e         src_n, src_q;
  logic             rsp_n, cfg_rd;
  logic [31:0]      cfg_word_q;

  for (genvar e = 0; e < EVT_Q; e++) begin : g_evt
    assign uflow_n[e] = pop_last  && sel_empty && qid == QID_W'(e);
    assign oflow_n[e] = push_last && sel_full  && qid == QID_W'(e);
  end

  assign rsp_n  = req_valid && !req_write;
  assign cfg_rd = rsp_n && kind == ACC_CFG;

  always_comb begin
    src_n = SRC_ZERO;
    if (pop_word || (idx_acc && !req_write)) src_n = SRC_RAM;
    else if (cfg_rd)                         src_n = SRC_CFG;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      src_q     <= SRC_ZERO;
      q_uflow   <= '0;
      q_oflow   <= '0;
    end else begin
      rsp_valid <= rsp_n;
      src_q     <= src_n;
      q_uflow   <= uflow_n;
      q_oflow   <= oflow_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_word_q <= '0;
    else if (cfg_rd) cfg_word_q <= cfg_pack(cur);
  end

  assign rsp_rdata = (src_q == SRC_RAM) ? ram_q :
                     (src_q == SRC_CFG) ? cfg_word_q : 32'd0;

  a_r12_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);
  a_r12_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rsp_valid);
  a_r6_overflow_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (push_last && sel_full && 32'(qid) < 32'(EVT_Q)) |=> $countones(q_oflow) == 1);
  a_r4_illegal_no_store: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == ACC_WIN && cur.esz == 2'd3) |-> !ram_we);
  a_r5_uflow_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_uflow));
endmodule

// File: tb/test_mq_fifo_mgr.sv
module test_mq_fifo_mgr;
  localparam int NQ = 64;

  logic        clk, rst_n, req_valid, req_write;
  logic [15:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_valid;
  logic [63:0] q_empty, q_nempty, q_nfull, q_full;
  logic [31:0] q_uflow, q_oflow;

  mq_fifo_mgr i_mq_fifo_mgr (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  int mdepth[NQ], mesz[NQ], mne[NQ], mnf[NQ];
  logic [31:0] mq[NQ][$];
  logic last_rv;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_rdata;
    last_rv = rsp_valid;
  endtask

  function automatic logic [31:0] exp_flags(input int q);
    int ent, dent;
    ent  = mq[q].size() / mesz[q];
    dent = mdepth[q] / mesz[q];
    return {28'd0, ent == dent, (dent - ent) <= mnf[q], ent <= mne[q], ent == 0};
  endfunction

  task automatic chk_flags(input int q, input string tag);
    chk(tag, {28'd0, q_full[q], q_nfull[q], q_nempty[q], q_empty[q]}, exp_flags(q));
  endtask

  task automatic set_cfg(input int q, input int base, input int dc, input int ez,
                         input int ne, input int nf);
    bus_wr(16'h0400 + 16'(q * 4), 32'(base) | (32'(dc) << 12) | (32'(ez) << 16) |
                                  (32'(ne) << 20) | (32'(nf) << 24));
    mdepth[q] = 16 << dc; mesz[q] = 1 << ez; mne[q] = ne; mnf[q] = nf;
    mq[q].delete();
  endtask

  task automatic push_ent(input int q, input logic [31:0] d0, input string tag);
    bit was_full;
    was_full = (mq[q].size() == mdepth[q]);
    for (int k = 0; k < mesz[q]; k++) bus_wr(16'(q * 16 + k * 4), d0 + 32'(k));
    if (!was_full) for (int k = 0; k < mesz[q]; k++) mq[q].push_back(d0 + 32'(k));
    chk({tag, " R6 overflow"}, 32'($countones(q_oflow)), 32'(was_full && q < 32));
    chk_flags(q, {tag, " R7 R8 flags"});
  endtask

  task automatic pop_ent(input int q, input string tag);
    bit was_empty;
    logic [31:0] d;
    was_empty = (mq[q].size() == 0);
    for (int k = 0; k < mesz[q]; k++) begin
      bus_rd(16'(q * 16 + k * 4), d);
      chk({tag, " R3 data"}, d, was_empty ? 32'd0 : mq[q][k]);
    end
    if (!was_empty) for (int k = 0; k < mesz[q]; k++) void'(mq[q].pop_front());
    chk({tag, " R5 underflow"}, 32'($countones(q_uflow)), 32'(was_empty && q < 32));
    chk_flags(q, {tag, " R7 R8 flags"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    for (int q = 0; q < NQ; q++) begin
      mdepth[q] = 16; mesz[q] = 1; mne[q] = 0; mnf[q] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk("R1 empty", q_empty[31:0], 32'hFFFF_FFFF);
    chk("R1 nempty", q_nempty[63:32], 32'hFFFF_FFFF);
    chk("R1 full", q_full[31:0] | q_nfull[31:0], 32'd0);
    chk("R1 events", q_uflow | q_oflow, 32'd0);
    bus_rd(16'h0400 + 16'(9 * 4), d);
    chk("R1 R9 reset cfg", d, 32'd0);
    chk("R12 rsp_valid on read", {31'd0, last_rv}, 32'd1);
    pop_ent(0, "R1 R5 pop after reset");

    // R3 R11: random pushes and pops on eight queues with separate ranges
    for (int q = 0; q < 8; q++)
      set_cfg(q, q * 128, $urandom_range(0, 3), $urandom_range(0, 2),
              $urandom_range(0, 7), $urandom_range(0, 7));
    chk("R12 no response to write", {31'd0, rsp_valid}, 32'd0);
    for (int i = 0; i < 1500; i++) begin
      int q;
      q = $urandom_range(0, 7);
      if ($urandom_range(0, 99) < 55) push_ent(q, $urandom, "R11 random push");
      else                            pop_ent(q, "R11 random pop");
    end

    // R9: readback masks undefined bits
    bus_wr(16'h0400 + 16'(7 * 4), 32'hFFFF_FFFF);
    bus_rd(16'h0400 + 16'(7 * 4), d);
    chk("R9 cfg readback", d, 32'h0773_37FF);

    // R6: fill a queue that reports events, then overflow it
    set_cfg(1, 16'h400, 0, 0, 2, 3);
    for (int i = 0; i < 16; i++) push_ent(1, 32'h100 + 32'(i), "R7 fill q1");
    push_ent(1, 32'hBAD0, "R6 push to full q1");

    // R10: peek and poke without moving pointers
    bus_rd(16'h8000 | 16'(1 << 9) | 16'(3 << 2), d);
    chk("R10 peek", d, 32'h103);
    bus_wr(16'h8000 | 16'(1 << 9) | 16'(3 << 2), 32'hABCD);
    mq[1][3] = 32'hABCD;
    chk_flags(1, "R10 flags unchanged after poke");
    for (int i = 0; i < 16; i++) pop_ent(1, "R10 drain q1");
    pop_ent(1, "R5 pop from empty q1");

    // R6: upper queue overflow is silent and drops data
    set_cfg(40, 16'h500, 0, 2, 0, 0);
    for (int i = 0; i < 5; i++) push_ent(40, 32'h4000 + 32'(i * 16), "R6 upper q40");
    for (int i = 0; i < 5; i++) pop_ent(40, "R6 drain upper q40");

    // R4: illegal entry width
    set_cfg(5, 16'h600, 0, 3, 0, 0);
    bus_wr(16'h8000 | 16'(5 << 9), 32'h1111);
    bus_wr(16'(5 * 16), 32'hDEAD);
    bus_rd(16'h8000 | 16'(5 << 9), d);
    chk("R4 illegal write not stored", d, 32'h1111);
    bus_rd(16'(5 * 16), d);
    chk("R4 illegal read zero", d, 32'd0);
    chk("R4 no event", q_uflow | q_oflow, 32'd0);
    chk("R4 still empty", {31'd0, q_empty[5]}, 32'd1);

    // R2: misaligned window write ignored
    set_cfg(2, 16'h700, 0, 0, 0, 0);
    bus_wr(16'(2 * 16 + 1), 32'h77);
    chk("R2 misaligned ignored", {31'd0, q_empty[2]}, 32'd1);

    // R13: RAM address beyond the buffer
    set_cfg(6, 16'h7F8, 0, 0, 0, 0);
    bus_wr(16'(6 * 16), 32'h55);
    bus_rd(16'(6 * 16), d);
    chk("R13 out-of-range reads zero", d, 32'd0);
    chk("R13 pointer moved", {31'd0, q_empty[6]}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule